// File: doc/BRIEF.md
# I2C Register-Access Target

This block lets an external I2C bus master read and write a bank of 128 byte-wide registers. It answers to one fixed 7-bit device address. Both bus lines are brought into the system clock domain through two-flop synchronizers. All bus events (clock edges, START, STOP) are found on the synchronized copies. The data line is driven as open drain: the block only ever asserts a pull-low enable.

Every transfer begins with the device address and a write direction bit. The next byte is a register selector. Its low seven bits load the register pointer, and its top bit turns on pointer advance after each data byte. Bytes that follow in the same write transfer go into the bank. To read, the master writes the selector first, then sends a repeated START with the read direction bit. The block then shifts bytes out of the bank until the master declines one. On-chip logic reaches the same bank through a local port with a registered read.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, and whenever the block is idle or ignoring the bus, `sda_oe` is 0.
- R2: An address byte whose upper seven bits equal 0x1D (binary 0011101) is acknowledged by pulling SDA low on the ninth clock; bit 0 of that byte selects the direction (1 read, 0 write). Any other address is not acknowledged, and the bytes that follow it change no register.
- R3: The byte after a write-direction address is acknowledged; bits 6..0 of it load the register pointer and bit 7 sets the auto-advance mode.
- R4: Each following write byte (MSB first) is stored at the pointer and acknowledged.
- R5: With auto-advance set, the pointer steps by one after each data byte; with it clear, every byte of a write overwrites the same register.
- R6: After a repeated START and a matching read-direction address, the block sends the register at the pointer, MSB first.
- R7: A master acknowledge (SDA low on the ninth clock) makes the block send the next byte, from the next register when auto-advance is set or the same one when clear; a not-acknowledge ends the read, and SDA stays released until STOP or START.
- R8: Auto-advance from register 127 wraps to register 0.
- R9: A STOP (SDA rising while SCL is high) returns the block to idle at any bit; a partly received byte is dropped and the next transfer works normally.
- R10: `sda_oe` only changes while the synchronized SCL is low.
- R11: The local port writes `loc_wdata` to `loc_addr` when `loc_we` is 1, and `loc_rdata` shows the register at `loc_addr` one clock after the address is applied.
- R12: A START (SDA falling while SCL is high) in the middle of any transfer drops the partial byte and makes the next byte an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| loc_we | input | 1 | Local write strobe |
| loc_addr | input | 7 | Local register index |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Register at `loc_addr`, one clock late |

## Verification
On every cycle the assertions check the line discipline. The data enable may only move while SCL is low. It stays off while the block is idle or ignoring the bus. It is on whenever a byte is being committed to the bank. A START always leads back to address decoding, and a STOP always leads back to idle. What reaches the register bank can only be shown by the bench's scenarios. These cover the contents left by single and burst writes, pointer advance and wrap, the byte order and continuation of reads, and the absence of effects after a wrong address, an aborted byte or a mid-transfer START.

// File: rtl/i2c_regs_pkg.sv
package i2c_regs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } bus_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_ff[1] & ~scl_d;
  assign scl_fall  = ~scl_ff[1] & scl_d;
  // data edges count only while SCL stays high across both samples
  assign start_det = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
  assign stop_det  = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_waddr,
  input  logic [DW-1:0] a_wdata,
  input  logic [AW-1:0] a_raddr,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_waddr] <= a_wdata;   // bus write wins on a collision
    a_rdata <= mem[a_raddr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_regs_pkg::*;
#(
  parameter int           AW       = 7,
  parameter int           DW       = 8,
  parameter logic [6:0]   DEV_ADDR = 7'h1D
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          sda_oe
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);
  localparam int IW = $clog2(DW);

  bus_state_e    state;
  logic [CW-1:0] cnt;
  logic          in_ack;
  logic [DW-1:0] sreg, tx;
  logic [AW-1:0] ptr;
  logic          auto_inc, rw, mack;

  assign mem_raddr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      in_ack   <= 1'b0;
      sreg     <= '0;
      tx       <= '0;
      ptr      <= '0;
      auto_inc <= 1'b0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      mem_we   <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (state != ST_IDLE && state != ST_IGNORE) begin
        if (scl_rise) begin
          if (cnt != LAST) begin
            sreg <= {sreg[DW-2:0], sda_s};
            cnt  <= cnt + 1'b1;
          end else if (in_ack) begin
            mack <= ~sda_s;
          end
        end else if (scl_fall) begin
          if (cnt != LAST) begin
            if (state == ST_RDATA && cnt != '0)
              sda_oe <= ~tx[IW'(LAST - 1'b1 - cnt)];
          end else if (!in_ack) begin
            // eighth bit done: decide the acknowledge
            in_ack <= 1'b1;
            case (state)
              ST_ADDR: begin
                if (sreg[DW-1:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= sreg[0];
                end else begin
                  state <= ST_IGNORE;
                end
              end
              ST_SUB: begin
                ptr      <= sreg[AW-1:0];
                auto_inc <= sreg[DW-1];
                sda_oe   <= 1'b1;
              end
              ST_WDATA: begin
                mem_we    <= 1'b1;
                mem_waddr <= ptr;
                mem_wdata <= sreg;
                sda_oe    <= 1'b1;
                if (auto_inc) ptr <= ptr + 1'b1;
              end
              ST_RDATA: begin
                sda_oe <= 1'b0;
                if (auto_inc) ptr <= ptr + 1'b1;
              end
              default: ;
            endcase
          end else begin
            // ninth clock done: start the next byte
            in_ack <= 1'b0;
            cnt    <= '0;
            case (state)
              ST_ADDR: begin
                if (rw) begin
                  state  <= ST_RDATA;
                  tx     <= mem_rdata;
                  sda_oe <= ~mem_rdata[DW-1];
                end else begin
                  state  <= ST_SUB;
                  sda_oe <= 1'b0;
                end
              end
              ST_SUB: begin
                state  <= ST_WDATA;
                sda_oe <= 1'b0;
              end
              ST_WDATA: sda_oe <= 1'b0;
              ST_RDATA: begin
                if (mack) begin
                  tx     <= mem_rdata;
                  sda_oe <= ~mem_rdata[DW-1];
                end else begin
                  state  <= ST_IGNORE;
                  sda_oe <= 1'b0;
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end
        end
      end
    end
  end

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(!scl_s));
  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);
  assert_write_acked_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> sda_oe);
  assert_start_to_addr_R12: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && !sda_oe));
  assert_stop_to_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !start_det) |=> state == ST_IDLE);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int         AW       = 7,
  parameter int         DW       = 8,
  parameter logic [6:0] DEV_ADDR = 7'h1D
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  i2c_line_sync u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_fsm #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .sda_oe(sda_oe)
  );

  i2c_regbank #(.AW(AW), .DW(DW)) u_bank (
    .clk(clk),
    .a_we(mem_we), .a_waddr(mem_waddr), .a_wdata(mem_wdata),
    .a_raddr(mem_raddr), .a_rdata(mem_rdata),
    .b_we(loc_we), .b_addr(loc_addr), .b_wdata(loc_wdata), .b_rdata(loc_rdata)
  );
endmodule

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h1D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, loc_we = 1'b0;
  logic [6:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0, loc_rdata;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, r10_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_reg_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );

  // R10 monitor: the enable must not move while the master holds SCL high
  logic oe_q = 1'b0;
  always @(negedge clk) begin
    if (!rst && scl && (sda_oe !== oe_q)) r10_bad++;
    oe_q <= sda_oe;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic give_ack);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~give_ack);
  endtask

  task automatic loc_wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); loc_addr = a; loc_wdata = d; loc_we = 1'b1;
    @(negedge clk); loc_we = 1'b0;
  endtask

  task automatic loc_rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk); loc_addr = a;
    @(negedge clk); d = loc_rdata;
  endtask

  task automatic t_reset();
    check("R1 reset sda_oe", sda_oe, 0);
  endtask

  task automatic t_local();
    logic [7:0] d;
    loc_wr(7'h05, 8'hA5); loc_rd(7'h05, d);
    check("R11 local readback", d, 8'hA5);
  endtask

  task automatic t_write_single();
    logic a; logic [7:0] d;
    bus_start();
    put_byte({DEV, 1'b0}, a); check("R2 address ack", a, 1);
    put_byte(8'h10, a);       check("R3 subaddr ack", a, 1);
    put_byte(8'h3C, a);       check("R4 data ack", a, 1);
    bus_stop();
    loc_rd(7'h10, d); check("R4 stored byte", d, 8'h3C);
  endtask

  task automatic t_burst_inc();
    logic a; logic [7:0] d;
    bus_start();
    put_byte({DEV, 1'b0}, a); put_byte(8'hA0, a);
    put_byte(8'h11, a); put_byte(8'h22, a); put_byte(8'h33, a);
    bus_stop();
    loc_rd(7'h20, d); check("R5 burst reg0", d, 8'h11);
    loc_rd(7'h21, d); check("R5 burst reg1", d, 8'h22);
    loc_rd(7'h22, d); check("R5 burst reg2", d, 8'h33);
  endtask

  task automatic t_burst_fixed();
    logic a; logic [7:0] d;
    loc_wr(7'h31, 8'h99);
    bus_start();
    put_byte({DEV, 1'b0}, a); put_byte(8'h30, a);
    put_byte(8'h44, a); put_byte(8'h55, a);
    bus_stop();
    loc_rd(7'h30, d); check("R5 fixed last wins", d, 8'h55);
    loc_rd(7'h31, d); check("R5 neighbour untouched", d, 8'h99);
  endtask

  task automatic t_read_inc();
    logic a, b; logic [7:0] d;
    loc_wr(7'h40, 8'h81); loc_wr(7'h41, 8'h7E); loc_wr(7'h42, 8'hC3);
    bus_start();
    put_byte({DEV, 1'b0}, a); put_byte(8'hC0, a);
    bus_start();
    put_byte({DEV, 1'b1}, a); check("R6 read address ack", a, 1);
    get_byte(d, 1'b1); check("R6 first read byte", d, 8'h81);
    get_byte(d, 1'b1); check("R7 continued byte", d, 8'h7E);
    get_byte(d, 1'b0); check("R7 third byte", d, 8'hC3);
    get_bit(b); check("R7 released after nack", b, 1);
    get_bit(b); check("R7 still released", b, 1);
    bus_stop();
  endtask

  task automatic t_read_fixed();
    logic a; logic [7:0] d;
    bus_start();
    put_byte({DEV, 1'b0}, a); put_byte(8'h41, a);
    bus_start();
    put_byte({DEV, 1'b1}, a);
    get_byte(d, 1'b1); check("R7 fixed read 1", d, 8'h7E);
    get_byte(d, 1'b0); check("R7 fixed read 2", d, 8'h7E);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] d;
    bus_start();
    put_byte({DEV, 1'b0}, a); put_byte(8'hFF, a);
    put_byte(8'hAA, a); put_byte(8'hBB, a);
    bus_stop();
    loc_rd(7'h7F, d); check("R8 top register", d, 8'hAA);
    loc_rd(7'h00, d); check("R8 wrapped to 0", d, 8'hBB);
  endtask

  task automatic t_mismatch();
    logic a; logic [7:0] d;
    loc_wr(7'h50, 8'h12);
    bus_start();
    put_byte({7'h1C, 1'b0}, a); check("R2 wrong address nack", a, 0);
    put_byte(8'h50, a);         check("R2 ignored subaddr", a, 0);
    put_byte(8'hEE, a);         check("R2 ignored data", a, 0);
    bus_stop();
    loc_rd(7'h50, d); check("R2 register untouched", d, 8'h12);
  endtask

  task automatic t_stop_mid();
    logic a; logic [7:0] d;
    loc_wr(7'h60, 8'h21);
    bus_start();
    put_byte({DEV, 1'b0}, a); put_byte(8'h60, a);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    loc_rd(7'h60, d); check("R9 partial byte dropped", d, 8'h21);
    check("R9 idle after stop", sda_oe, 0);
    bus_start();
    put_byte({DEV, 1'b0}, a); check("R9 next transfer ack", a, 1);
    put_byte(8'h60, a); put_byte(8'h6B, a);
    bus_stop();
    loc_rd(7'h60, d); check("R9 next transfer stores", d, 8'h6B);
  endtask

  task automatic t_restart();
    logic a; logic [7:0] d;
    loc_wr(7'h70, 8'h0F);
    bus_start();
    put_byte({DEV, 1'b0}, a); put_byte(8'h70, a);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
    bus_start();
    put_byte({DEV, 1'b0}, a); check("R12 address after restart", a, 1);
    put_byte(8'h71, a); put_byte(8'h5A, a);
    bus_stop();
    loc_rd(7'h70, d); check("R12 aborted byte dropped", d, 8'h0F);
    loc_rd(7'h71, d); check("R12 new write stored", d, 8'h5A);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_local();
    t_write_single();
    t_burst_inc();
    t_burst_fixed();
    t_read_inc();
    t_read_fixed();
    t_wrap();
    t_mismatch();
    t_stop_mid();
    t_restart();
    check("R10 oe moved with SCL high", r10_bad, 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule